// File: doc/BRIEF.md
# Codirectional 64 kbit/s Receive Decoder with Octet Alignment

This block sits behind the line receiver of a 64 kbit/s codirectional link. It takes two active-low pulse lines, one per polarity, and clocks them with a 2.048 MHz reference. From these it produces three things. The first is a 128 kHz half-bit clock that follows the timing of the incoming pulses. The second is the stream of decoded data bits, packed into octets. The third is an alarm that shows whether octet alignment is held.

Each data bit is sent as two half-bit pulses. A bit is a one when both pulses have the same polarity, and a zero when the polarity flips at mid-bit. At each bit boundary the polarity normally alternates. The transmitter breaks this rule on purpose at the start of every octet: the first pulse of the octet repeats the polarity of the pulse before it. That repeated polarity is a violation, and it marks the octet boundary.

The block hunts for these violations and confirms that they recur every eight bits. Once they do, it delivers one octet per strobe. While the violations keep arriving on schedule the alarm stays low. When they stop arriving, the block raises the alarm.

Top module: `codir_rx_decoder`

## Requirements
- R1: While reset is held, `viol_alarm` is 1, `octet_vld` is 0 and `rec_clk` is 1.
- R2: A falling edge on either line restarts the half-bit timing. Take the reference edge at which the line is first seen low as edge 0. Then `rec_clk` is low after edge 1 if its earlier phase puts it there, high after edges 2 to 9, and low after edges 10 and 11. Without new falling edges, `rec_clk` repeats with a period of 16 reference cycles, high for the first 8.
- R3: Each pulse on exactly one line is one half-bit symbol. `line_pos_n` low means positive polarity and `line_neg_n` low means negative polarity. A decoded bit is 1 when the two symbols of the bit have equal polarity and 0 when they differ. The first bit received is bit 7 (MSB) of `octet_data`.
- R4: `octet_vld` is a one-cycle pulse, raised once per decoded octet while alignment is held, and never while `viol_alarm` is 1.
- R5: A violation is a symbol at a bit boundary that repeats the polarity of the previous symbol. Alignment is declared on the third violation in a row when the violations are spaced 16 symbols (8 bits) apart. At that point `viol_alarm` falls, and the octet that begins with the third violation is the first one delivered. If an expected violation is absent during this confirmation, the count restarts.
- R6: While aligned, a boundary without a violation is a miss. One or two misses in a row are tolerated: octets are still delivered and the alarm stays low. A violation that arrives clears the miss count. The third miss in a row raises `viol_alarm`, and the octet that starts at that boundary is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_pos_n | input | 1 | Positive-polarity pulse line, active low |
| line_neg_n | input | 1 | Negative-polarity pulse line, active low |
| rec_clk | output | 1 | Recovered 128 kHz half-bit clock |
| octet_data | output | 8 | Last decoded octet, first received bit in the MSB |
| octet_vld | output | 1 | One-cycle strobe marking a new `octet_data` |
| viol_alarm | output | 1 | High while octet alignment is not held |

## Verification
A slot counter that loses step with the octet shows up at the ports in two ways. The delivered octets come out rotated or bit-inverted, because ones and zeros are swapped when the wrong symbol pair is compared. The alarm also changes state one octet early or late. Both effects are visible within one octet, which is 256 reference cycles. A fault in the half-bit counter shows within one symbol as a shifted `rec_clk` edge. A miss or hit counter with the wrong limit changes the octet at which the alarm falls or rises, so each count boundary is driven exactly and the octets delivered around it are compared one by one.

// File: rtl/codir_rx_pkg.sv
package codir_rx_pkg;
  typedef enum logic [1:0] {
    SY_HUNT    = 2'd0,
    SY_CONFIRM = 2'd1,
    SY_LOCK    = 2'd2
  } sync_state_e;
endpackage

// File: rtl/codir_clk_recover.sv
// Half-bit timing recovery: synchronise both pulse lines, restart a
// divide-by-DIV counter on each falling edge, sample polarity once per slot.
module codir_clk_recover #(
  parameter int DIV         = 16,
  parameter int SAMPLE_AT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_pos_n,
  input  logic line_neg_n,
  output logic rec_clk,
  output logic sym_stb,
  output logic sym_pol
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_SAMP = CW'(SAMPLE_AT);
  localparam logic [CW-1:0] CNT_HALF = CW'(DIV / 2);

  logic [SYNC_STAGES-1:0] pos_sync_q, neg_sync_q;
  logic pos_s, neg_s, pos_d_q, neg_d_q, fall_edge;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic stb_nxt, pol_nxt;

  assign pos_s     = pos_sync_q[SYNC_STAGES-1];
  assign neg_s     = neg_sync_q[SYNC_STAGES-1];
  assign fall_edge = (pos_d_q & ~pos_s) | (neg_d_q & ~neg_s);

  always_comb begin
    if (fall_edge)              cnt_nxt = '0;
    else if (cnt_q == CNT_LAST) cnt_nxt = '0;
    else                        cnt_nxt = cnt_q + 1'b1;
    stb_nxt = (cnt_q == CNT_SAMP) && (pos_s ^ neg_s);
    pol_nxt = ~pos_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_sync_q <= '1;
      neg_sync_q <= '1;
      pos_d_q    <= 1'b1;
      neg_d_q    <= 1'b1;
      cnt_q      <= '0;
      sym_stb    <= 1'b0;
      sym_pol    <= 1'b0;
    end else begin
      pos_sync_q <= SYNC_STAGES'({pos_sync_q, line_pos_n});
      neg_sync_q <= SYNC_STAGES'({neg_sync_q, line_neg_n});
      pos_d_q    <= pos_s;
      neg_d_q    <= neg_s;
      cnt_q      <= cnt_nxt;
      sym_stb    <= stb_nxt;
      if (stb_nxt) sym_pol <= pol_nxt;
    end
  end

  assign rec_clk = (cnt_q < CNT_HALF);

  // R2: a symbol is always taken in the high half of the recovered clock
  p_strobe_in_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> rec_clk);
  // R3: one symbol per slot, never two strobes back to back
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);
endmodule

// File: rtl/codir_octet_sync.sv
// Violation detection, octet alignment state machine and bit packing.
module codir_octet_sync
  import codir_rx_pkg::*;
#(
  parameter int OCT_BITS  = 8,
  parameter int LOCK_HITS = 3,
  parameter int MISS_LIM  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_stb,
  input  logic                sym_pol,
  output logic [OCT_BITS-1:0] octet_data,
  output logic                octet_vld,
  output logic                viol_alarm
);
  localparam int SLOTS = 2 * OCT_BITS;
  localparam int PW    = $clog2(SLOTS);
  localparam int HW    = $clog2(LOCK_HITS + 1);
  localparam int MW    = $clog2(MISS_LIM + 1);
  localparam int SH_W  = OCT_BITS - 1;
  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);
  localparam logic [HW-1:0] HIT_FULL  = HW'(LOCK_HITS - 1);
  localparam logic [MW-1:0] MISS_FULL = MW'(MISS_LIM - 1);

  sync_state_e state_q, state_nxt;
  logic [PW-1:0] pos_q, pos_nxt;
  logic [HW-1:0] hits_q, hits_nxt;
  logic [MW-1:0] miss_q, miss_nxt;
  logic [SH_W-1:0] sh_q, sh_nxt;
  logic [OCT_BITS-1:0] data_nxt;
  logic have_prev_q, last_pol_q, vld_nxt, alarm_nxt, same;

  // equal polarity with the previous symbol
  assign same = have_prev_q && (sym_pol == last_pol_q);

  always_comb begin
    state_nxt = state_q;
    pos_nxt   = pos_q;
    hits_nxt  = hits_q;
    miss_nxt  = miss_q;
    sh_nxt    = sh_q;
    data_nxt  = octet_data;
    alarm_nxt = viol_alarm;
    vld_nxt   = 1'b0;
    if (sym_stb) begin
      pos_nxt = (pos_q == LAST_SLOT) ? '0 : pos_q + 1'b1;
      if (pos_q[0]) sh_nxt = SH_W'({sh_q, same});
      if (pos_q == LAST_SLOT && state_q == SY_LOCK) begin
        data_nxt = {sh_q, same};
        vld_nxt  = 1'b1;
      end
      unique case (state_q)
        SY_HUNT: if (same) begin
          state_nxt = SY_CONFIRM;
          pos_nxt   = PW'(1);
          hits_nxt  = HW'(1);
        end
        SY_CONFIRM: if (pos_q == '0) begin
          if (!same) state_nxt = SY_HUNT;
          else if (hits_q == HIT_FULL) begin
            state_nxt = SY_LOCK;
            miss_nxt  = '0;
            alarm_nxt = 1'b0;
          end else hits_nxt = hits_q + 1'b1;
        end
        SY_LOCK: if (pos_q == '0) begin
          if (same) miss_nxt = '0;
          else if (miss_q == MISS_FULL) begin
            state_nxt = SY_HUNT;
            alarm_nxt = 1'b1;
          end else miss_nxt = miss_q + 1'b1;
        end
        default: state_nxt = SY_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SY_HUNT;
      pos_q       <= '0;
      hits_q      <= '0;
      miss_q      <= '0;
      sh_q        <= '0;
      have_prev_q <= 1'b0;
      last_pol_q  <= 1'b0;
      octet_data  <= '0;
      octet_vld   <= 1'b0;
      viol_alarm  <= 1'b1;
    end else begin
      octet_vld <= vld_nxt;
      if (sym_stb) begin
        state_q     <= state_nxt;
        pos_q       <= pos_nxt;
        hits_q      <= hits_nxt;
        miss_q      <= miss_nxt;
        sh_q        <= sh_nxt;
        have_prev_q <= 1'b1;
        last_pol_q  <= sym_pol;
        octet_data  <= data_nxt;
        viol_alarm  <= alarm_nxt;
      end
    end
  end

  // R5: alignment is only ever gained on a symbol that repeats polarity
  p_lock_on_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol_alarm) |-> $past(sym_stb && same));
  // R6: alignment is only ever lost on a boundary without a repeat
  p_loss_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_alarm) |-> $past(sym_stb && !same));
  // R6: the miss count never reaches the loss limit while held
  p_miss_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < MW'(MISS_LIM));
  // R4: octets only while aligned
  p_vld_when_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    octet_vld |-> !viol_alarm);
  // R4: the strobe lasts one cycle
  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    octet_vld |=> !octet_vld);
endmodule

// File: rtl/codir_rx_decoder.sv
module codir_rx_decoder #(
  parameter int DIV         = 16,
  parameter int SAMPLE_AT   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OCT_BITS    = 8,
  parameter int LOCK_HITS   = 3,
  parameter int MISS_LIM    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_pos_n,
  input  logic                line_neg_n,
  output logic                rec_clk,
  output logic [OCT_BITS-1:0] octet_data,
  output logic                octet_vld,
  output logic                viol_alarm
);
  logic [1:0] rst_pipe_q;
  logic core_rst_n, sym_stb, sym_pol;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  codir_clk_recover #(
    .DIV(DIV), .SAMPLE_AT(SAMPLE_AT), .SYNC_STAGES(SYNC_STAGES)
  ) recover_i (
    .clk(clk), .rst_n(core_rst_n),
    .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
    .rec_clk(rec_clk), .sym_stb(sym_stb), .sym_pol(sym_pol)
  );

  codir_octet_sync #(
    .OCT_BITS(OCT_BITS), .LOCK_HITS(LOCK_HITS), .MISS_LIM(MISS_LIM)
  ) sync_i (
    .clk(clk), .rst_n(core_rst_n),
    .sym_stb(sym_stb), .sym_pol(sym_pol),
    .octet_data(octet_data), .octet_vld(octet_vld), .viol_alarm(viol_alarm)
  );
endmodule

// File: tb/codir_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module codir_rx_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n, line_pos_n, line_neg_n;
  logic rec_clk, octet_vld, viol_alarm;
  logic [7:0] octet_data;

  int n_checks = 0;
  int n_bad = 0;
  int n_double = 0;
  logic prev_vld = 1'b0;
  logic tx_last = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  codir_rx_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
    .rec_clk(rec_clk), .octet_data(octet_data), .octet_vld(octet_vld),
    .viol_alarm(viol_alarm)
  );

  // octet collector, sampled between edges
  always @(posedge clk) begin
    #2;
    if (octet_vld) rx_q.push_back(octet_data);
    if (octet_vld && prev_vld) n_double++;
    prev_vld = octet_vld;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_pos_n = 1'b1; line_neg_n = 1'b1; tx_last = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    check(viol_alarm == 1'b1, "R1 alarm in reset", viol_alarm, 1);
    check(octet_vld == 1'b0, "R1 vld in reset", octet_vld, 0);
    check(rec_clk == 1'b1, "R1 rec_clk in reset", rec_clk, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_q.delete();
  endtask

  // one half-bit slot; called on a falling clock edge, returns on one
  task automatic send_half(input logic pol, input int len);
    if (pol) line_pos_n = 1'b0; else line_neg_n = 1'b0;
    repeat (8) @(negedge clk);
    line_pos_n = 1'b1; line_neg_n = 1'b1;
    repeat (len - 8) @(negedge clk);
  endtask

  task automatic send_octet(input logic [7:0] d, input bit viol);
    for (int k = 7; k >= 0; k--) begin
      logic first, second;
      first  = (viol && k == 7) ? tx_last : ~tx_last;
      second = d[k] ? first : ~first;
      send_half(first, 16);
      send_half(second, 16);
      tx_last = second;
    end
  endtask

  task automatic check_bytes(input string req);
    repeat (40) @(negedge clk);
    check(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      check(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
    rx_q.delete();
    exp_q.delete();
  endtask

  // R2: resynchronisation of the half-bit clock on an early pulse
  task automatic t_resync();
    int bad_lo1 = 0, bad_hi = 0, bad_lo2 = 0;
    do_reset();
    send_half(1'b1, 16); send_half(1'b0, 16); send_half(1'b1, 16);
    send_half(1'b0, 10);
    line_pos_n = 1'b0;
    for (int j = 0; j < 12; j++) begin
      @(posedge clk); #2;
      if (j == 1 && rec_clk !== 1'b0) bad_lo1++;
      if (j >= 2 && j <= 9 && rec_clk !== 1'b1) bad_hi++;
      if (j >= 10 && rec_clk !== 1'b0) bad_lo2++;
      @(negedge clk);
      if (j == 7) line_pos_n = 1'b1;
    end
    check(bad_lo1 == 0, "R2 low before restart", bad_lo1, 0);
    check(bad_hi == 0, "R2 high for 8 after restart", bad_hi, 0);
    check(bad_lo2 == 0, "R2 low in second half", bad_lo2, 0);
  endtask

  // R3 R5: acquisition then decoding of several patterns
  task automatic t_lock_decode();
    do_reset();
    @(negedge clk);
    send_octet(8'h00, 1); send_octet(8'h00, 1); send_octet(8'h00, 1);
    check(viol_alarm == 1'b1, "R5 two violations not enough", viol_alarm, 1);
    check(rx_q.size() == 0, "R5 no octet before lock", rx_q.size(), 0);
    send_octet(8'h00, 1);
    check(viol_alarm == 1'b0, "R5 lock on third violation", viol_alarm, 0);
    send_octet(8'hA5, 1); send_octet(8'h3C, 1);
    send_octet(8'hFF, 1); send_octet(8'h81, 1);
    exp_q = '{8'h00, 8'hA5, 8'h3C, 8'hFF, 8'h81};
    check_bytes("R3 decoded octets");
  endtask

  // R6: tolerated misses, then loss
  task automatic t_miss_loss();
    send_octet(8'h5A, 0); send_octet(8'hC3, 0);
    check(viol_alarm == 1'b0, "R6 two misses tolerated", viol_alarm, 0);
    send_octet(8'h00, 1);
    send_octet(8'h77, 0); send_octet(8'h00, 0);
    check(viol_alarm == 1'b0, "R6 count cleared by violation", viol_alarm, 0);
    send_octet(8'h00, 0);
    check(viol_alarm == 1'b1, "R6 third miss raises alarm", viol_alarm, 1);
    send_octet(8'h00, 0);
    exp_q = '{8'h5A, 8'hC3, 8'h00, 8'h77, 8'h00};
    check_bytes("R6 octets around loss");
    check(viol_alarm == 1'b1, "R6 alarm held while hunting", viol_alarm, 1);
  endtask

  // R5: relock after loss
  task automatic t_relock();
    send_octet(8'h00, 1); send_octet(8'h00, 1); send_octet(8'h00, 1);
    send_octet(8'h5A, 1);
    exp_q = '{8'h00, 8'h5A};
    check_bytes("R5 relock octets");
    check(viol_alarm == 1'b0, "R5 relocked", viol_alarm, 0);
  endtask

  // R5: an absent violation during confirmation restarts the count
  task automatic t_broken_run();
    do_reset();
    @(negedge clk);
    send_octet(8'h00, 1); send_octet(8'h00, 1); send_octet(8'h00, 1);
    send_octet(8'h00, 0);
    send_octet(8'h00, 1); send_octet(8'h00, 1);
    check(viol_alarm == 1'b1, "R5 run restarted after gap", viol_alarm, 1);
    send_octet(8'h00, 1); send_octet(8'hAB, 1);
    exp_q = '{8'h00, 8'hAB};
    check_bytes("R5 lock after restarted run");
  endtask

  initial begin
    t_resync();
    t_lock_decode();
    t_miss_loss();
    t_relock();
    t_broken_run();
    check(n_double == 0, "R4 strobe one cycle wide", n_double, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule